// File: doc/BRIEF.md
# Restricted I/O Program Validator

This block screens the 16-bit instruction words of a small programmable I/O state machine before they are written into its instruction memory. Each word is decoded by opcode and field. Any word that could drive pins outside an eight-pin window, raise an interrupt, jump outside the program, or redirect the program counter is rejected. Reserved encodings are rejected as well.

A loader first pulses `start_i` together with the declared program length. It then presents the program one word at a time with `word_valid_i`. One cycle after each word, the block reports a verdict and a reason code. It also keeps a sticky program-level fail flag that holds the index and reason of the first failing word. The loader uses that flag to refuse the whole program.

A policy input decides whether instructions that write pin levels or pin directions through the configured window are allowed.

Top module: `ioprog_screen`

## Requirements
- R1: For every cycle with `word_valid_i` high, `verdict_valid_o` is high in the following cycle, with `verdict_ok_o` and `verdict_reason_o` (0 when accepted); with no valid word it is low in the following cycle.
- R2: Every word with opcode bits [15:13] = 110 (interrupt) is rejected with reason 1.
- R3: A jump (opcode 000) is accepted only if its target bits [4:0] are less than the declared program length; otherwise reason 2. The length is captured on `start_i` and is 0 after reset.
- R4: A wait (opcode 001) with source bits [6:5] = 10 is rejected with reason 3. With source 00 or 01 the pin index bits [4:0] must be below 8, otherwise reason 4. Source 11 is accepted.
- R5: An in (opcode 010) with source bits [7:5] = 100 or 101 is rejected with reason 5; all other sources are accepted.
- R6: An out (opcode 011) with destination bits [7:5] = 101 or 111 is rejected with reason 6. Destination 000 or 100 is rejected with reason 7 unless `pin_write_en_i` is high. All other destinations are accepted.
- R7: A move (opcode 101) is checked in this order. Destination bits [7:5] = 011 or 101 gives reason 8. Otherwise, operation bits [4:3] = 11 gives reason 10. Otherwise, source bits [2:0] = 100 gives reason 9. Any other move is accepted.
- R8: A set (opcode 111) with destination bits [7:5] = 011, 101, 110 or 111 is rejected with reason 11. Destination 000 or 100 is rejected with reason 7 unless `pin_write_en_i` is high. X (001) and Y (010) are accepted.
- R9: A push/pull (opcode 100) is accepted only if bits [4:0] are all zero; otherwise reason 12.
- R10: Bits [12:8] (delay and side-set) never change a verdict.
- R11: Counting valid words from 0 since the last `start_i`, the index and reason of the first rejected word are held on `fail_index_o` and `fail_reason_o`. `prog_fail_o` stays high and those values stay unchanged until the next `start_i`.
- R12: `start_i` clears the fail flag, index and reason to 0 and restarts the word count. A word presented in the same cycle as `start_i` is word 0 and is judged against the newly declared length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start-of-program marker |
| prog_len_i | input | ADDR_W+1 | Declared program length, sampled with `start_i` |
| pin_write_en_i | input | 1 | Policy: allow writes to pin levels and directions |
| word_valid_i | input | 1 | Instruction word present |
| word_i | input | 16 | Instruction word |
| verdict_valid_o | output | 1 | Verdict for the previous cycle's word |
| verdict_ok_o | output | 1 | Word accepted |
| verdict_reason_o | output | 4 | Reason code, 0 when accepted |
| prog_fail_o | output | 1 | Sticky: some word since start was rejected |
| fail_index_o | output | IDX_W | Index of the first rejected word |
| fail_reason_o | output | 4 | Reason code of the first rejected word |

## Verification
The hardest case to reach is a word that arrives in the same cycle as a new start marker while the previous program still holds a recorded failure. That word must be judged against the new length, numbered 0, and allowed to replace the old failure record. The stimulus first builds a failing program, then restarts it with a shorter length and an out-of-range jump in the same cycle. Sustained rejection is covered by feeding several failing words in a row, so that only the first one is recorded. An exhaustive sweep of every low byte under every opcode, with both policy settings, compares each verdict against an independent model.

// File: rtl/ioprog_screen_pkg.sv
package ioprog_screen_pkg;

  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    OP_JMP      = 3'd0,
    OP_WAIT     = 3'd1,
    OP_IN       = 3'd2,
    OP_OUT      = 3'd3,
    OP_PUSHPULL = 3'd4,
    OP_MOV      = 3'd5,
    OP_IRQ      = 3'd6,
    OP_SET      = 3'd7
  } opcode_e;

  typedef enum logic [3:0] {
    RS_OK         = 4'd0,
    RS_IRQ        = 4'd1,
    RS_JMP_RANGE  = 4'd2,
    RS_WAIT_IRQ   = 4'd3,
    RS_WAIT_PIN   = 4'd4,
    RS_IN_RSVD    = 4'd5,
    RS_OUT_DEST   = 4'd6,
    RS_PIN_POLICY = 4'd7,
    RS_MOV_DEST   = 4'd8,
    RS_MOV_SRC    = 4'd9,
    RS_MOV_OP     = 4'd10,
    RS_SET_DEST   = 4'd11,
    RS_FIXED_BITS = 4'd12
  } reason_e;

  // destinations 000 and 100 address pin levels or pin directions
  function automatic logic is_pin_target(input logic [2:0] dst);
    return (dst == 3'b000) || (dst == 3'b100);
  endfunction

  function automatic logic set_dest_reserved(input logic [2:0] dst);
    return (dst == 3'b011) || (dst[2] && (dst[1:0] != 2'b00));
  endfunction

endpackage

// File: rtl/ioprog_decode.sv
module ioprog_decode
  import ioprog_screen_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int PIN_WIN = 8
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [ADDR_W:0]   len_i,
  input  logic              pin_write_en_i,
  output reason_e           reason_o,
  output logic              jmp_out_of_range_o,
  output logic              pin_policy_hit_o
);

  localparam int LEN_W = ADDR_W + 1;
  localparam logic [4:0] PIN_LIM = 5'(PIN_WIN);

  opcode_e            op;
  logic [2:0]         fld_hi;
  logic [1:0]         wait_src;
  logic [4:0]         fld_lo;
  logic [ADDR_W-1:0]  jmp_addr;
  logic               unused_delay;

  assign op           = opcode_e'(word_i[15:13]);
  assign fld_hi       = word_i[7:5];
  assign wait_src     = word_i[6:5];
  assign fld_lo       = word_i[4:0];
  assign jmp_addr     = word_i[ADDR_W-1:0];
  assign unused_delay = ^word_i[12:8];

  assign jmp_out_of_range_o = (op == OP_JMP) && (LEN_W'({1'b0, jmp_addr}) >= len_i);
  assign pin_policy_hit_o   = ((op == OP_OUT) || (op == OP_SET)) && is_pin_target(fld_hi)
                              && !pin_write_en_i;

  always_comb begin
    reason_o = RS_OK;
    unique case (op)
      OP_JMP:  if (jmp_out_of_range_o) reason_o = RS_JMP_RANGE;
      OP_WAIT: begin
        if (wait_src == 2'b10) reason_o = RS_WAIT_IRQ;
        else if (wait_src != 2'b11 && fld_lo >= PIN_LIM) reason_o = RS_WAIT_PIN;
      end
      OP_IN:   if (fld_hi[2:1] == 2'b10) reason_o = RS_IN_RSVD;
      OP_OUT: begin
        if (fld_hi == 3'b101 || fld_hi == 3'b111) reason_o = RS_OUT_DEST;
        else if (pin_policy_hit_o) reason_o = RS_PIN_POLICY;
      end
      OP_PUSHPULL: if (|fld_lo) reason_o = RS_FIXED_BITS;
      OP_MOV: begin
        if (fld_hi == 3'b011 || fld_hi == 3'b101) reason_o = RS_MOV_DEST;
        else if (word_i[4:3] == 2'b11) reason_o = RS_MOV_OP;
        else if (word_i[2:0] == 3'b100) reason_o = RS_MOV_SRC;
      end
      OP_IRQ: reason_o = RS_IRQ;
      OP_SET: begin
        if (set_dest_reserved(fld_hi)) reason_o = RS_SET_DEST;
        else if (pin_policy_hit_o) reason_o = RS_PIN_POLICY;
      end
      default: reason_o = RS_OK;
    endcase
  end

endmodule

// File: rtl/ioprog_track.sv
module ioprog_track
  import ioprog_screen_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  input  reason_e          reason_i,
  output logic             verdict_valid_o,
  output logic             verdict_ok_o,
  output reason_e          verdict_reason_o,
  output logic             fail_o,
  output logic [IDX_W-1:0] fail_index_o,
  output reason_e          fail_reason_o
);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] cur_idx;
  logic             word_bad;
  logic             first_bad;

  assign cur_idx   = start_i ? '0 : idx_q;
  assign word_bad  = valid_i && (reason_i != RS_OK);
  assign first_bad = word_bad && (start_i || !fail_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q            <= '0;
      verdict_valid_o  <= 1'b0;
      verdict_ok_o     <= 1'b0;
      verdict_reason_o <= RS_OK;
      fail_o           <= 1'b0;
      fail_index_o     <= '0;
      fail_reason_o    <= RS_OK;
    end else begin
      idx_q            <= valid_i ? cur_idx + 1'b1 : cur_idx;
      verdict_valid_o  <= valid_i;
      verdict_ok_o     <= valid_i && (reason_i == RS_OK);
      verdict_reason_o <= valid_i ? reason_i : RS_OK;
      if (first_bad) begin
        fail_o        <= 1'b1;
        fail_index_o  <= cur_idx;
        fail_reason_o <= reason_i;
      end else if (start_i) begin
        fail_o        <= 1'b0;
        fail_index_o  <= '0;
        fail_reason_o <= RS_OK;
      end
    end
  end

  // R1: one verdict cycle per presented word
  a_r1_verdict_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> verdict_valid_o);
  a_r1_no_spurious_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !verdict_valid_o);
  // R11: the failure record holds until a new start
  a_r11_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> fail_o);
  a_r11_record_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !start_i |=> $stable(fail_index_o) && $stable(fail_reason_o));
  // R12: a start with no word clears the record
  a_r12_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !valid_i |=> !fail_o && fail_index_o == '0);
  // R11: a rejected verdict always comes with the fail flag
  a_r11_flag_on_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o && !verdict_ok_o |-> fail_o);

endmodule

// File: rtl/ioprog_screen.sv
module ioprog_screen
  import ioprog_screen_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = 8,
  parameter int PIN_WIN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [ADDR_W:0]  prog_len_i,
  input  logic             pin_write_en_i,
  input  logic             word_valid_i,
  input  logic [15:0]      word_i,
  output logic             verdict_valid_o,
  output logic             verdict_ok_o,
  output logic [3:0]       verdict_reason_o,
  output logic             prog_fail_o,
  output logic [IDX_W-1:0] fail_index_o,
  output logic [3:0]       fail_reason_o
);

  logic [ADDR_W:0] len_q;
  logic [ADDR_W:0] eff_len;
  reason_e         word_reason;
  reason_e         v_reason;
  reason_e         f_reason;
  logic            jmp_oor;
  logic            pin_hit;

  assign eff_len = start_i ? prog_len_i : len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      len_q <= '0;
    else if (start_i) len_q <= prog_len_i;
  end

  ioprog_decode #(.ADDR_W(ADDR_W), .PIN_WIN(PIN_WIN)) u_decode (
    .word_i             (word_i),
    .len_i              (eff_len),
    .pin_write_en_i     (pin_write_en_i),
    .reason_o           (word_reason),
    .jmp_out_of_range_o (jmp_oor),
    .pin_policy_hit_o   (pin_hit)
  );

  ioprog_track #(.IDX_W(IDX_W)) u_track (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .start_i          (start_i),
    .valid_i          (word_valid_i),
    .reason_i         (word_reason),
    .verdict_valid_o  (verdict_valid_o),
    .verdict_ok_o     (verdict_ok_o),
    .verdict_reason_o (v_reason),
    .fail_o           (prog_fail_o),
    .fail_index_o     (fail_index_o),
    .fail_reason_o    (f_reason)
  );

  assign verdict_reason_o = v_reason;
  assign fail_reason_o    = f_reason;

  // R2: interrupt opcode never passes
  a_r2_irq_rejected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_i[15:13] == 3'b110 |=> verdict_valid_o && !verdict_ok_o);
  // R3: out-of-range jump is flagged and rejected
  a_r3_jump_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && jmp_oor |=> !verdict_ok_o && verdict_reason_o == 4'd2);
  // R6/R8: pin write without policy never passes
  a_r6_pin_policy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && pin_hit |=> !verdict_ok_o);
  // R6: execute destination of an out never passes
  a_r6_exec_dest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_valid_i && word_i[15:13] == 3'b011 && word_i[7:5] == 3'b111
    |=> verdict_reason_o == 4'd6);
  // R1: an accepted verdict carries reason 0
  a_r1_ok_reason_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_ok_o |-> verdict_valid_o && verdict_reason_o == 4'd0);

endmodule

// File: tb/test_ioprog_screen.sv
module test_ioprog_screen;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  prog_len_i = '0;
  logic        pin_write_en_i = 1'b0;
  logic        word_valid_i = 1'b0;
  logic [15:0] word_i = '0;
  logic        verdict_valid_o, verdict_ok_o, prog_fail_o;
  logic [3:0]  verdict_reason_o, fail_reason_o;
  logic [7:0]  fail_index_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk_i = ~clk_i;

  ioprog_screen i_ioprog_screen (
    .clk_i, .rst_ni, .start_i, .prog_len_i, .pin_write_en_i,
    .word_valid_i, .word_i, .verdict_valid_o, .verdict_ok_o,
    .verdict_reason_o, .prog_fail_o, .fail_index_o, .fail_reason_o
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent model of the reason code
  function automatic int model(input logic [15:0] w, input int len, input bit allow);
    int d;
    int lo;
    d  = int'(w[7:5]);
    lo = int'(w[4:0]);
    case (w[15:13])
      3'd0: return (lo < len) ? 0 : 2;
      3'd1: begin
        if (w[6:5] == 2'b10) return 3;
        if (w[6:5] != 2'b11 && lo > 7) return 4;
        return 0;
      end
      3'd2: return (d == 4 || d == 5) ? 5 : 0;
      3'd3: begin
        if (d == 5 || d == 7) return 6;
        if ((d == 0 || d == 4) && !allow) return 7;
        return 0;
      end
      3'd4: return (lo != 0) ? 12 : 0;
      3'd5: begin
        if (d == 3 || d == 5) return 8;
        if (w[4:3] == 2'b11) return 10;
        if (w[2:0] == 3'b100) return 9;
        return 0;
      end
      3'd6: return 1;
      default: begin
        if (d == 3 || d >= 5) return 11;
        if ((d == 0 || d == 4) && !allow) return 7;
        return 0;
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R9";
      3'd5: return "R7";
      3'd6: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic begin_prog(input int len);
    @(negedge clk_i);
    start_i = 1'b1;
    prog_len_i = 6'(len);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // drive one word, check verdict one cycle later
  task automatic send(input string tag, input logic [15:0] w, input int exp_reason,
                      input bit with_start = 1'b0, input int len = 0);
    @(negedge clk_i);
    word_valid_i = 1'b1;
    word_i = w;
    start_i = with_start;
    if (with_start) prog_len_i = 6'(len);
    @(negedge clk_i);
    word_valid_i = 1'b0;
    start_i = 1'b0;
    chk({tag, " R1 valid"}, int'(verdict_valid_o), 1);
    chk({tag, " ok"}, int'(verdict_ok_o), (exp_reason == 0) ? 1 : 0);
    chk({tag, " reason"}, int'(verdict_reason_o), exp_reason);
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    chk("R1 reset verdict_valid", int'(verdict_valid_o), 0);
    chk("R11 reset fail", int'(prog_fail_o), 0);
    chk("R11 reset index", int'(fail_index_o), 0);
    chk("R11 reset reason", int'(fail_reason_o), 0);
    send("R3 jump before any start", 16'h0000, 2);
    @(negedge clk_i);
    chk("R1 idle no verdict", int'(verdict_valid_o), 0);
  endtask

  task automatic t_directed;
    pin_write_en_i = 1'b0;
    begin_prog(8);
    send("R2 irq", 16'hC000, 1);
    send("R3 jump last", 16'h0007, 0);
    send("R3 jump at length", 16'h0008, 2);
    send("R4 wait irq src", 16'h2040, 3);
    send("R4 wait pin 7", 16'h2087, 0);
    send("R4 wait pin 8", 16'h2008, 4);
    send("R4 wait jmp-pin idx 31", 16'h207F, 0);
    send("R5 in src 101", 16'h40A0, 5);
    send("R6 out exec", 16'h60E0, 6);
    send("R6 out pins no policy", 16'h6000, 7);
    send("R6 out isr", 16'h60C0, 0);
    send("R7 mov pc dest plus bad op", 16'hA0BC, 8);
    send("R7 mov op 11 plus bad src", 16'hA03C, 10);
    send("R7 mov src 100", 16'hA024, 9);
    send("R8 set rsvd", 16'hE0C0, 11);
    send("R8 set pindirs no policy", 16'hE080, 7);
    send("R9 pull clean", 16'h80A0, 0);
    send("R9 push dirty", 16'h8001, 12);
    pin_write_en_i = 1'b1;
    send("R6 out pins policy", 16'h6000, 0);
    send("R8 set pins policy", 16'hE01F, 0);
    pin_write_en_i = 1'b0;
    begin_prog(32);
    send("R3 jump 31 len 32", 16'h001F, 0);
  endtask

  task automatic t_delay_bits;
    begin_prog(4);
    send("R10 jump delay 0", 16'h0003, 0);
    send("R10 jump delay all", 16'h1F03, 0);
    send("R10 set delay all", 16'hFF20, 0);
    send("R10 irq delay", 16'hD500, 1);
  endtask

  task automatic t_sweep;
    for (int a = 0; a < 2; a++) begin
      pin_write_en_i = a[0];
      begin_prog(20);
      for (int op = 0; op < 8; op++) begin
        for (int lo = 0; lo < 256; lo++) begin
          logic [15:0] w;
          w = {3'(op), 5'(lo) ^ 5'h15, 8'(lo)};
          send({tag_of(3'(op)), " R10 sweep"}, w, model(w, 20, a[0]));
        end
      end
    end
    pin_write_en_i = 1'b0;
  endtask

  task automatic t_sticky;
    begin_prog(4);
    chk("R12 start clears fail", int'(prog_fail_o), 0);
    chk("R12 start clears index", int'(fail_index_o), 0);
    send("R11 word0", 16'hE021, 0);
    send("R11 word1", 16'h0002, 0);
    send("R11 word2 irq", 16'hC000, 1);
    send("R11 word3 bad jump", 16'h001F, 2);
    send("R11 word4 ok", 16'hA021, 0);
    chk("R11 fail held", int'(prog_fail_o), 1);
    chk("R11 first index", int'(fail_index_o), 2);
    chk("R11 first reason", int'(fail_reason_o), 1);
  endtask

  task automatic t_start_same_cycle;
    // a failure record is held from t_sticky
    send("R12 word with start", 16'h0005, 2, 1'b1, 2);
    chk("R12 fail set", int'(prog_fail_o), 1);
    chk("R12 index zero", int'(fail_index_o), 0);
    chk("R12 reason new", int'(fail_reason_o), 2);
    send("R12 new len used", 16'h0001, 0);
    send("R12 later fail ignored", 16'hC000, 1);
    chk("R11 index kept", int'(fail_index_o), 0);
    send("R12 start with good word", 16'h0009, 0, 1'b1, 16);
    chk("R12 cleared by start", int'(prog_fail_o), 0);
    send("R12 index after start", 16'h8001, 12);
    chk("R12 second word index", int'(fail_index_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_directed();
    t_delay_bits();
    t_sweep();
    t_sticky();
    t_start_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule